// File: doc/BRIEF.md
# Page Access Rights Checker

This block sits after the translation lookup of a memory-management unit. It receives the protection fields of the entry the lookup found and the details of the current access. From these it computes the physical address, the mask of rights the access may use and a fault code. The rights come from a three-bit page type and two privilege bounds. Execute is granted only inside a privilege window. A protection-key comparison against four key registers can withdraw write permission. Dirty, break and reference conditions are then checked in turn, and each later check overrides the fault an earlier one chose.

Everything except the fault-address capture is combinational. When a fault is reported and the capture enable is high, the next clock edge stores the virtual address in two registers: the low word in one and the upper bits in the other. The lookup itself and the dispatch of the reported fault belong to the surrounding logic.

Top module: `page_rights_chk`

## Requirements
- R1: With `xlat_off` high, `pa` equals the low PA_W bits of `va`, `rights` is 3'b111 and `fault` is 0, whatever the entry holds.
- R2: With translation on and `hit` low, `rights` is 0, `pa` is 0 and `fault` is 1 (instruction miss) for an execute access and 2 (data miss) for any other access kind.
- R3: Rights bit 0 (read) is granted when `priv` <= `ent_pl_rd`, bit 1 (write) when `priv` <= `ent_pl_wr`, and bit 2 (execute) only when `ent_pl_wr` <= `priv` <= `ent_pl_rd`. Level 0 is the most privileged.
- R4: The page type selects which of these grants apply: 0 read only, 1 read and write, 2 read and execute, 3 read, write and execute, 4 to 7 execute only.
- R5: When `pid_en` is high and `ent_key` is nonzero, and {`ent_key`,1'b1} zero-extended equals any of the four PID_W-bit slices of `pid_regs`, write is removed from `rights`. A write access (`acc`=2) then reports fault 3 and no later check runs.
- R6: A probe (`acc`=0) on a hit reports fault 0 and returns the mask left after the R3 to R5 stages, with no dirty, break or reference narrowing.
- R7: If the requested right (`acc` 1 read, 2 write, 3 execute) is absent from the mask, the fault is 4 for execute and 5 otherwise, and the mask is returned without narrowing.
- R8: With `ent_dirty` low, a write faults with code 6, and write is removed from the mask for every access kind.
- R9: With `ent_brk` high, a write faults with code 7, overriding R8, and write is removed from the mask.
- R10: With `ent_ref` high, a read or write faults with code 8, overriding R8 and R9, and the mask keeps only execute. An execute access keeps fault 0.
- R11: On a clock edge where `fault` is nonzero and `capt_en` is high, `ior_q` takes `va`[LO_W-1:0] and `isr_q` takes `va`[VA_W-1:LO_W]. Otherwise both hold. Reset clears both.
- R12: On a hit with translation on, `pa` is {`ent_pfn`, `va`[PAGE_BITS-1:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the capture registers |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_off | input | 1 | Translation disabled: direct mapping |
| hit | input | 1 | Lookup found a valid entry |
| va | input | VA_W | Virtual address of the access |
| ent_pfn | input | PA_W-PAGE_BITS | Physical frame number of the entry |
| ent_type | input | 3 | Page type code |
| ent_pl_rd | input | 2 | Least privileged level allowed to read |
| ent_pl_wr | input | 2 | Least privileged level allowed to write |
| ent_key | input | KEY_W | Protection key of the page, 0 means public |
| ent_dirty | input | 1 | Page dirty bit |
| ent_brk | input | 1 | Data break bit |
| ent_ref | input | 1 | Reference trap bit |
| priv | input | 2 | Current privilege level |
| acc | input | 2 | Access kind: 0 probe, 1 read, 2 write, 3 execute |
| pid_en | input | 1 | Protection-key checking enabled |
| pid_regs | input | NPID*PID_W | Four packed key registers, slice i at [i*PID_W +: PID_W] |
| capt_en | input | 1 | Enable for capturing the faulting address |
| pa | output | PA_W | Physical address |
| rights | output | 3 | Allowed rights: bit 0 read, bit 1 write, bit 2 execute |
| fault | output | 4 | Fault code, 0 for none |
| ior_q | output | LO_W | Captured low word of the faulting address |
| isr_q | output | VA_W-LO_W | Captured upper bits of the faulting address |

## Verification
Directed cases place `priv` below, at, between and above the two bounds for several page types. Random stimulus varies all eight types over every privilege combination, which tells the read and write bounds apart from the execute window. Key registers are set to the matching value {key,1} about half the time, and the key is sometimes zero. These cases separate key-based suppression from its enable and from the public-page exemption. Dirty, break and reference bits are set alone and in combination for every access kind, including probes. This exposes both the override order and the masks each stage leaves, and the capture registers are compared against the last faulting address after every cycle.

// File: rtl/prc_pkg.sv
// Shared codes for the page rights checker.
// Assumes rights bit order read/write/execute and a 4-bit fault code with 0 = none.
package prc_pkg;
    typedef enum logic [1:0] {
        ACC_PROBE = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_EXEC  = 2'd3
    } acc_e;

    typedef enum logic [3:0] {
        F_NONE        = 4'd0,
        F_ITLB_MISS   = 4'd1,
        F_DTLB_MISS   = 4'd2,
        F_PID_WRITE   = 4'd3,
        F_INSN_PROT   = 4'd4,
        F_DATA_RIGHTS = 4'd5,
        F_DIRTY       = 4'd6,
        F_BREAK       = 4'd7,
        F_PAGE_REF    = 4'd8
    } fault_e;

    localparam int RB_READ  = 0;
    localparam int RB_WRITE = 1;
    localparam int RB_EXEC  = 2;
endpackage

// File: rtl/prc_base_rights.sv
// Base rights from page type and privilege bounds.
// Assumes level 0 is most privileged. Types 4..7 all decode to execute only.
module prc_base_rights (
    input  logic [1:0] priv,
    input  logic [1:0] pl_rd,
    input  logic [1:0] pl_wr,
    input  logic [2:0] typ,
    output logic [2:0] base
);
    import prc_pkg::*;

    logic rd_ok, wr_ok, ex_ok;

    // Privilege comparisons for each right
    always_comb begin
        rd_ok = (priv <= pl_rd);
        wr_ok = (priv <= pl_wr);
        ex_ok = (pl_wr <= priv) && (priv <= pl_rd);
    end

    // Type code selects which grants apply
    always_comb begin
        base = '0;
        case (typ)
            3'd0: base[RB_READ] = rd_ok;
            3'd1: begin base[RB_READ] = rd_ok; base[RB_WRITE] = wr_ok; end
            3'd2: begin base[RB_READ] = rd_ok; base[RB_EXEC]  = ex_ok; end
            3'd3: begin
                base[RB_READ]  = rd_ok;
                base[RB_WRITE] = wr_ok;
                base[RB_EXEC]  = ex_ok;
            end
            default: base[RB_EXEC] = ex_ok;
        endcase
    end
endmodule

// File: rtl/prc_pid_match.sv
// Protection-key comparator against NPID key registers.
// Assumes PID_W > KEY_W + 1. A zero key marks a public page and never matches.
module prc_pid_match #(
    parameter int KEY_W = 18,
    parameter int PID_W = 32,
    parameter int NPID  = 4
) (
    input  logic                    pid_en,
    input  logic [KEY_W-1:0]        key,
    input  logic [NPID*PID_W-1:0]   pid_regs,
    output logic                    pid_hit
);
    localparam int PAD_W = PID_W - KEY_W - 1;

    logic [PID_W-1:0] cand;
    logic [NPID-1:0]  eq;

    // Candidate value: key shifted up with the low bit set
    assign cand = {{PAD_W{1'b0}}, key, 1'b1};

    // One comparator per key register
    for (genvar i = 0; i < NPID; i++) begin : g_cmp
        assign eq[i] = (pid_regs[i*PID_W +: PID_W] == cand);
    end

    // Match counts only when enabled and the page is not public
    assign pid_hit = pid_en && (|key) && (|eq);
endmodule

// File: rtl/prc_fault_chain.sv
// Resolves the final rights mask and fault code.
// Assumes base rights and key match are already computed; the order of stages sets priority.
module prc_fault_chain (
    input  logic       xlat_off,
    input  logic       hit,
    input  logic [1:0] acc,
    input  logic [2:0] base,
    input  logic       pid_hit,
    input  logic       dirty,
    input  logic       brk,
    input  logic       refb,
    output logic [2:0] rights,
    output logic [3:0] fault
);
    import prc_pkg::*;

    logic [2:0] req;
    logic       is_wr, is_ex;

    // Decode the requested right
    always_comb begin
        is_wr = (acc == ACC_WRITE);
        is_ex = (acc == ACC_EXEC);
        case (acc)
            ACC_READ:  req = 3'b001;
            ACC_WRITE: req = 3'b010;
            ACC_EXEC:  req = 3'b100;
            default:   req = 3'b000;
        endcase
    end

    // Staged checks; each later stage may override the earlier fault
    always_comb begin
        rights = '0;
        fault  = F_NONE;
        if (xlat_off) begin
            rights = 3'b111;
        end else if (!hit) begin
            fault = is_ex ? F_ITLB_MISS : F_DTLB_MISS;
        end else begin
            rights = base;
            if (pid_hit) begin
                rights[RB_WRITE] = 1'b0;
                if (is_wr) fault = F_PID_WRITE;
            end
            if (fault == F_NONE && acc != ACC_PROBE) begin
                if ((rights & req) == 3'b000) begin
                    fault = is_ex ? F_INSN_PROT : F_DATA_RIGHTS;
                end else begin
                    if (!dirty) begin
                        if (is_wr) fault = F_DIRTY;
                        rights[RB_WRITE] = 1'b0;
                    end
                    if (brk) begin
                        if (is_wr) fault = F_BREAK;
                        rights[RB_WRITE] = 1'b0;
                    end
                    if (refb) begin
                        if (!is_ex) fault = F_PAGE_REF;
                        rights = rights & 3'b100;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/prc_capture.sv
// Registers the faulting virtual address, split into low word and upper bits.
// Assumes a synchronous active-low reset; holds when no fault or capture disabled.
module prc_capture #(
    parameter int VA_W = 64,
    parameter int LO_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 faulted,
    input  logic                 capt_en,
    input  logic [VA_W-1:0]      va,
    output logic [LO_W-1:0]      ior_q,
    output logic [VA_W-LO_W-1:0] isr_q
);
    localparam int HI_W = VA_W - LO_W;

    // Latch address halves on an enabled fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ior_q <= '0;
            isr_q <= '0;
        end else if (faulted && capt_en) begin
            ior_q <= va[LO_W-1:0];
            isr_q <= va[VA_W-1 -: HI_W];
        end
    end

    AST_CAPTURE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (faulted && capt_en) |=> (ior_q == $past(va[LO_W-1:0]))); // R11
    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(faulted && capt_en) |=> ($stable(ior_q) && $stable(isr_q))); // R11
endmodule

// File: rtl/page_rights_chk.sv
// Page access rights checker: rights mask, fault code, physical address and
// fault-address capture. Assumes VA_W >= PA_W > PAGE_BITS and that hit already
// means the entry is valid.
module page_rights_chk #(
    parameter int VA_W      = 64,
    parameter int LO_W      = 32,
    parameter int PA_W      = 40,
    parameter int PAGE_BITS = 12,
    parameter int KEY_W     = 18,
    parameter int PID_W     = 32,
    parameter int NPID      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       xlat_off,
    input  logic                       hit,
    input  logic [VA_W-1:0]            va,
    input  logic [PA_W-PAGE_BITS-1:0]  ent_pfn,
    input  logic [2:0]                 ent_type,
    input  logic [1:0]                 ent_pl_rd,
    input  logic [1:0]                 ent_pl_wr,
    input  logic [KEY_W-1:0]           ent_key,
    input  logic                       ent_dirty,
    input  logic                       ent_brk,
    input  logic                       ent_ref,
    input  logic [1:0]                 priv,
    input  logic [1:0]                 acc,
    input  logic                       pid_en,
    input  logic [NPID*PID_W-1:0]      pid_regs,
    input  logic                       capt_en,
    output logic [PA_W-1:0]            pa,
    output logic [2:0]                 rights,
    output logic [3:0]                 fault,
    output logic [LO_W-1:0]            ior_q,
    output logic [VA_W-LO_W-1:0]       isr_q
);
    import prc_pkg::*;

    localparam int PFN_W = PA_W - PAGE_BITS;

    logic [2:0] base;
    logic       pid_hit;

    prc_base_rights u_base (
        .priv  (priv),
        .pl_rd (ent_pl_rd),
        .pl_wr (ent_pl_wr),
        .typ   (ent_type),
        .base  (base)
    );

    prc_pid_match #(.KEY_W(KEY_W), .PID_W(PID_W), .NPID(NPID)) u_pid (
        .pid_en   (pid_en),
        .key      (ent_key),
        .pid_regs (pid_regs),
        .pid_hit  (pid_hit)
    );

    prc_fault_chain u_chain (
        .xlat_off (xlat_off),
        .hit      (hit),
        .acc      (acc),
        .base     (base),
        .pid_hit  (pid_hit),
        .dirty    (ent_dirty),
        .brk      (ent_brk),
        .refb     (ent_ref),
        .rights   (rights),
        .fault    (fault)
    );

    // Physical address: direct map, frame plus offset, or zero on a miss
    always_comb begin
        if (xlat_off)  pa = va[PA_W-1:0];
        else if (hit)  pa = {ent_pfn[PFN_W-1:0], va[PAGE_BITS-1:0]};
        else           pa = '0;
    end

    prc_capture #(.VA_W(VA_W), .LO_W(LO_W)) u_capt (
        .clk     (clk),
        .rst_n   (rst_n),
        .faulted (fault != 4'd0),
        .capt_en (capt_en),
        .va      (va),
        .ior_q   (ior_q),
        .isr_q   (isr_q)
    );

    AST_DIRECT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_off |-> (rights == 3'b111 && fault == 4'd0 && pa == va[PA_W-1:0])); // R1
    AST_MISS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlat_off && !hit) |-> (rights == 3'b000 && (fault == 4'd1 || fault == 4'd2))); // R2
    AST_EXEC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlat_off && rights[2]) |-> (ent_pl_wr <= priv && priv <= ent_pl_rd)); // R3
    AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlat_off && hit && acc == 2'd0) |-> (fault == 4'd0)); // R6
    AST_REF_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlat_off && hit && ent_ref && fault == 4'd8) |-> (rights[1:0] == 2'b00)); // R10
endmodule

// File: tb/page_rights_chk_test.sv
module page_rights_chk_test;
    localparam int VA_W = 64, LO_W = 32, PA_W = 40, PAGE_BITS = 12;
    localparam int KEY_W = 18, PID_W = 32, NPID = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xlat_off, hit, ent_dirty, ent_brk, ent_ref, pid_en, capt_en;
    logic [VA_W-1:0] va;
    logic [PA_W-PAGE_BITS-1:0] ent_pfn;
    logic [2:0] ent_type;
    logic [1:0] ent_pl_rd, ent_pl_wr, priv, acc;
    logic [KEY_W-1:0] ent_key;
    logic [NPID*PID_W-1:0] pid_regs;
    logic [PA_W-1:0] pa;
    logic [2:0] rights;
    logic [3:0] fault;
    logic [LO_W-1:0] ior_q;
    logic [VA_W-LO_W-1:0] isr_q;

    int n_tests = 0, n_fail = 0;
    logic [VA_W-1:0] exp_cap_va = '0;

    always #5 clk = ~clk;

    page_rights_chk uut (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: returns {rights, fault}
    function automatic logic [6:0] model();
        logic [2:0] r, req;
        logic [3:0] f;
        logic rd, wr, ex, pm;
        r = 3'b000; f = 4'd0;
        if (xlat_off) return {3'b111, 4'd0};
        if (!hit) return {3'b000, (acc == 2'd3) ? 4'd1 : 4'd2};
        rd = priv <= ent_pl_rd;
        wr = priv <= ent_pl_wr;
        ex = (priv >= ent_pl_wr) && (priv <= ent_pl_rd);
        case (ent_type)
            3'd0: r = {1'b0, 1'b0, rd};
            3'd1: r = {1'b0, wr, rd};
            3'd2: r = {ex, 1'b0, rd};
            3'd3: r = {ex, wr, rd};
            default: r = {ex, 1'b0, 1'b0};
        endcase
        pm = 1'b0;
        for (int i = 0; i < NPID; i++)
            if (pid_regs[i*PID_W +: PID_W] == {13'd0, ent_key, 1'b1}) pm = 1'b1;
        if (pid_en && ent_key != 0 && pm) begin
            r[1] = 1'b0;
            if (acc == 2'd2) return {r, 4'd3};
        end
        if (acc == 2'd0) return {r, 4'd0};
        req = (acc == 2'd1) ? 3'b001 : (acc == 2'd2) ? 3'b010 : 3'b100;
        if ((r & req) == 0) return {r, (acc == 2'd3) ? 4'd4 : 4'd5};
        if (!ent_dirty) begin if (acc == 2'd2) f = 4'd6; r[1] = 1'b0; end
        if (ent_brk)    begin if (acc == 2'd2) f = 4'd7; r[1] = 1'b0; end
        if (ent_ref)    begin if (acc != 2'd3) f = 4'd8; r = r & 3'b100; end
        return {r, f};
    endfunction

    function automatic logic [PA_W-1:0] model_pa();
        if (xlat_off) return va[PA_W-1:0];
        if (hit) return {ent_pfn, va[PAGE_BITS-1:0]};
        return '0;
    endfunction

    // Apply current inputs: check comb outputs, then capture after the edge
    task automatic step(input string tag);
        logic [6:0] m;
        #1;
        m = model();
        check({tag, " rights"}, 64'(rights), 64'(m[6:4]));
        check({tag, " fault"}, 64'(fault), 64'(m[3:0]));
        check({tag, " R12 pa"}, 64'(pa), 64'(model_pa()));
        if (m[3:0] != 0 && capt_en) exp_cap_va = va;
        @(posedge clk); #1;
        check("R11 ior", 64'(ior_q), 64'(exp_cap_va[LO_W-1:0]));
        check("R11 isr", 64'(isr_q), 64'(exp_cap_va[VA_W-1:LO_W]));
        @(negedge clk);
    endtask

    task automatic defaults();
        xlat_off = 0; hit = 1; va = 64'h0000_00AB_CDEF_1234; ent_pfn = 28'h1234567;
        ent_type = 3'd3; ent_pl_rd = 2'd3; ent_pl_wr = 2'd0; ent_key = '0;
        ent_dirty = 1; ent_brk = 0; ent_ref = 0; priv = 2'd0; acc = 2'd1;
        pid_en = 0; pid_regs = '0; capt_en = 1;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        defaults();
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset ior", 64'(ior_q), 64'd0);
        check("R11 reset isr", 64'(isr_q), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: direct mapping ignores a missing entry
        defaults(); xlat_off = 1; hit = 0; va = 64'h1122_3344_5566_7788; acc = 2'd2;
        #1; check("R1 rights", 64'(rights), 64'h7); check("R1 fault", 64'(fault), 64'h0);
        check("R1 pa", 64'(pa), 64'h44_5566_7788);
        step("R1");

        // R2: miss kinds
        defaults(); hit = 0; acc = 2'd3; va = 64'hDEAD_BEEF_0000_0010;
        #1; check("R2 exec miss", 64'(fault), 64'h1); check("R2 rights", 64'(rights), 64'h0);
        step("R2");
        acc = 2'd1; #1; check("R2 data miss", 64'(fault), 64'h2);
        step("R2");
        check("R11 captured hi", 64'(isr_q), 64'hDEAD_BEEF);

        // R3: privilege bounds on type 3, bounds rd=2 wr=1
        defaults(); ent_pl_rd = 2'd2; ent_pl_wr = 2'd1; acc = 2'd0;
        priv = 2'd0; #1; check("R3 priv0", 64'(rights), 64'h3);
        priv = 2'd2; #1; check("R3 priv2", 64'(rights), 64'h5);
        priv = 2'd3; acc = 2'd1; #1; check("R3 priv3 rights", 64'(rights), 64'h0);
        check("R7 read denied", 64'(fault), 64'h5);
        acc = 2'd3; #1; check("R7 exec denied", 64'(fault), 64'h4);
        step("R3");

        // R4: type 6 is execute only
        defaults(); ent_type = 3'd6; priv = 2'd1; acc = 2'd0;
        #1; check("R4 type6", 64'(rights), 64'h4);
        ent_type = 3'd0; #1; check("R4 type0", 64'(rights), 64'h1);

        // R5: key match removes write and faults a write
        defaults(); ent_key = 18'd5; pid_en = 1; pid_regs[2*PID_W +: PID_W] = 32'd11; acc = 2'd2;
        #1; check("R5 write fault", 64'(fault), 64'h3); check("R5 rights", 64'(rights), 64'h5);
        pid_en = 0; #1; check("R5 disabled", 64'(fault), 64'h0);
        pid_en = 1; ent_key = '0; pid_regs[2*PID_W +: PID_W] = 32'd1; #1;
        check("R5 public key", 64'(fault), 64'h0);
        step("R5");

        // R6: probe skips D/B/T
        defaults(); acc = 2'd0; ent_dirty = 0; ent_brk = 1; ent_ref = 1;
        #1; check("R6 probe fault", 64'(fault), 64'h0); check("R6 probe rights", 64'(rights), 64'h7);

        // R8 R9 R10: override order
        acc = 2'd2; ent_brk = 0; ent_ref = 0; #1; check("R8 dirty", 64'(fault), 64'h6);
        check("R8 mask", 64'(rights), 64'h5);
        ent_brk = 1; #1; check("R9 break", 64'(fault), 64'h7);
        ent_ref = 1; #1; check("R10 ref over break", 64'(fault), 64'h8);
        check("R10 mask", 64'(rights), 64'h4);
        acc = 2'd3; #1; check("R10 exec no fault", 64'(fault), 64'h0);
        check("R10 exec mask", 64'(rights), 64'h4);
        capt_en = 0; acc = 2'd1; va = 64'h5555_5555_5555_5555; step("R11 capture off");

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            int unsigned sel;
            xlat_off = ($urandom % 16) == 0;
            hit = ($urandom % 8) != 0;
            va = {$urandom, $urandom};
            ent_pfn = 28'($urandom);
            ent_type = 3'($urandom); ent_pl_rd = 2'($urandom); ent_pl_wr = 2'($urandom);
            priv = 2'($urandom); acc = 2'($urandom);
            ent_key = (($urandom % 4) == 0) ? '0 : 18'($urandom % 64);
            ent_dirty = ($urandom % 4) != 0; ent_brk = ($urandom % 4) == 0;
            ent_ref = ($urandom % 4) == 0;
            pid_en = $urandom % 2; capt_en = ($urandom % 4) != 0;
            for (int i = 0; i < NPID; i++) begin
                sel = $urandom % 8;
                pid_regs[i*PID_W +: PID_W] = (sel == 0) ? {13'd0, ent_key, 1'b1} : $urandom;
            end
            step("R3 R4 R5 R7 R8 R9 R10 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule